// File: doc/BRIEF.md
# Configurable Timer/Counter with Buffered High Byte

This block is a small timer/counter peripheral attached to a byte-wide register bus. It advances either on an internal instruction tick (one tick every four system clocks) or on edges of an external input pin. The edge polarity is selectable, and an optional prescaler divides the event stream by a power of two. The counter is either 8 or 16 bits wide. When it wraps, a sticky overflow flag is raised on a dedicated output and stays set until software clears it.

In 16-bit mode software never touches the true high byte directly. A buffer register stands in for it. Reading the low byte copies the true high byte into the buffer, so a two-access read always returns a matching pair. Writing the low byte loads the buffer into the high byte in the same cycle, so a two-access write is atomic. Any write of the counter holds off incrementing for the next two instruction ticks and restarts the prescaler.

Register map (address on `bus_addr`): 0 control, 1 counter low byte, 2 high-byte buffer, 3 flag. The control byte holds these fields:
- bit 7: run
- bit 6: 16-bit mode
- bit 5: falling-edge select
- bit 4: external source
- bit 3: prescaler bypass
- bits 2:0: prescale select

Top module: `evt_timer`

## Requirements
- R1: After reset the control byte reads 0x9F: run=1, 8-bit mode, rising edge, external source, prescaler bypassed, prescale select 111. The counter low byte, the buffer and the flag (address 3, bit 0) all read 0, and `ovf_flag` is 0.
- R2: With bit 4=0 and bit 3=1, the counter advances by one for every four system clocks.
- R3: After a write to address 1 (the low byte), the next two instruction ticks are not counted, and neither is any external edge that arrives before those ticks have passed. N ticks after the write, the count reads the written value plus max(N-2, 0).
- R4: With bit 3=0, the counter advances once per 2^(sel+1) accepted events, where sel is bits 2:0. A write to the low byte restarts the prescaler.
- R5: With bit 4=1 and bit 5=0, each rising edge of `ext_in` advances the counter by one after a two-flop synchronizer.
- R6: With bit 4=1 and bit 5=1, each falling edge of `ext_in` advances the counter by one, and rising edges are not counted.
- R7: In 16-bit mode (bit 6=1), a read of address 1 copies the true high byte into the buffer at address 2. A later buffer read returns the high byte that matched the low byte read, even if the counter has moved on since.
- R8: A write to address 2 changes only the buffer. In 16-bit mode, a write to address 1 loads the low byte from the bus and the high byte from the buffer in one cycle.
- R9: The flag is set when the counter wraps, from 0xFF in 8-bit mode or from 0xFFFF in 16-bit mode. In 8-bit mode the true high byte is never changed by counting or by a low-byte write.
- R10: The flag stays set until a write to address 3 with bit 0=0 clears it. An overflow in the same cycle as that write wins.
- R11: With bit 7=0, the counter does not change except through a bus write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (side effect on address 1) |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from the address |
| ext_in | input | 1 | External count input, asynchronous |
| ovf_flag | output | 1 | Sticky overflow flag |

## Verification
The in-RTL assertions check these properties on every cycle:
- The counter is frozen while the write hold-off is active and while the run bit is clear.
- A buffer write alone never moves the counter.
- In 8-bit mode the high byte never moves.
- A wrap always raises the flag, and the flag stays set until software writes it.
- The synchronized edge pulse lasts a single cycle.

The exact counts need the bench's scenarios to show:
- the per-tick advance,
- the two-tick hold-off after a write,
- every prescale ratio,
- the polarity of external edges,
- the matched-pair behaviour of the high-byte buffer while the counter crosses a byte boundary.

// File: rtl/evt_timer_pkg.sv
// Package: shared register addresses, control-byte layout and reset value
// for the timer/counter. Assumes a byte-wide register bus.
package evt_timer_pkg;

    localparam int BYTE_W = 8;
    localparam int ADDR_W = 2;
    localparam int PS_W   = 3;

    typedef enum logic [ADDR_W-1:0] {
        A_CTRL   = 2'd0,
        A_CNT_LO = 2'd1,
        A_CNT_HI = 2'd2,
        A_FLAG   = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic            run;
        logic            wide;
        logic            fall;
        logic            ext;
        logic            bypass;
        logic [PS_W-1:0] sel;
    } ctrl_t;

    localparam ctrl_t CTRL_RST = '{run: 1'b1, wide: 1'b0, fall: 1'b0, ext: 1'b1,
                                   bypass: 1'b1, sel: 3'b111};

endpackage

// File: rtl/evt_timer_edge.sv
// Module: synchronizes the asynchronous count pin through STAGES flops and
// turns the selected edge polarity into a one-cycle pulse.
// Assumes: pin held low through reset (a high pin looks like a rising edge).
module evt_timer_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic fall_sel,
    output logic pulse
);

    logic [STAGES-1:0] sync_q;
    logic              last_q;
    logic              cur;

    generate
        if (STAGES == 1) begin : g_one
            // single-stage capture of the pin
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= pin;
            end
        end else begin : g_many
            // shift the pin through the synchronizer chain
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= {sync_q[STAGES-2:0], pin};
            end
        end
    endgenerate

    assign cur = sync_q[STAGES-1];

    // remember the previous synchronized level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) last_q <= 1'b0;
        else        last_q <= cur;
    end

    // pick the edge polarity requested by software
    assign pulse = fall_sel ? (last_q & ~cur) : (~last_q & cur);

    // R5: an edge pulse lasts exactly one cycle while polarity is unchanged
    assert_one_cycle_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |=> (!pulse || (fall_sel != $past(fall_sel))));

endmodule

// File: rtl/evt_timer_pace.sv
// Module: produces the counter step strobe. It holds the instruction-tick
// divider, the post-write hold-off and the power-of-two prescaler.
// Assumes: load is a one-cycle strobe for a write of the counter low byte.
module evt_timer_pace #(
    parameter int TICK_DIV   = 4,
    parameter int HOLD_TICKS = 2,
    parameter int PS_W       = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic            ext_sel,
    input  logic            bypass,
    input  logic [PS_W-1:0] sel,
    input  logic            ext_pulse,
    input  logic            load,
    output logic            step,
    output logic            hold_busy
);

    localparam int PH_W   = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam int HOLD_W = $clog2(HOLD_TICKS + 1);
    localparam int PRE_W  = 1 << PS_W;

    logic [PH_W-1:0]   phase_q;
    logic              tick;
    logic [HOLD_W-1:0] hold_q;
    logic [PRE_W-1:0]  pre_q;
    logic [PRE_W-1:0]  pre_mask;
    logic              pre_full;
    logic              raw_evt;
    logic              accepted;

    // free-running instruction-cycle divider
    always_ff @(posedge clk) begin
        if (!rst_n)                                phase_q <= '0;
        else if (phase_q == PH_W'(TICK_DIV - 1))   phase_q <= '0;
        else                                       phase_q <= phase_q + PH_W'(1);
    end

    assign tick = (phase_q == PH_W'(TICK_DIV - 1));

    // hold-off counter: armed by a counter write, drained by instruction ticks
    always_ff @(posedge clk) begin
        if (!rst_n)                         hold_q <= '0;
        else if (load)                      hold_q <= HOLD_W'(HOLD_TICKS);
        else if (tick && (hold_q != '0))    hold_q <= hold_q - HOLD_W'(1);
    end

    assign hold_busy = (hold_q != '0);

    // select the event source and gate it with run and hold-off
    assign raw_evt  = ext_sel ? ext_pulse : tick;
    assign accepted = raw_evt & run & ~hold_busy & ~load;

    // mask of the prescaler bits in use for ratio 2^(sel+1)
    always_comb begin
        for (int i = 0; i < PRE_W; i++) pre_mask[i] = (i <= int'(sel));
    end

    assign pre_full = ((pre_q & pre_mask) == pre_mask);

    // prescaler count, restarted on a counter write
    always_ff @(posedge clk) begin
        if (!rst_n)                     pre_q <= '0;
        else if (load)                  pre_q <= '0;
        else if (accepted && !bypass)   pre_q <= pre_full ? '0 : pre_q + PRE_W'(1);
    end

    assign step = accepted & (bypass | pre_full);

    // R2: instruction ticks never come on back-to-back cycles
    assert_tick_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && (TICK_DIV > 1)) |=> !tick);

    // R4: a counter write restarts the prescaler from zero
    assert_prescale_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (pre_q == '0));

endmodule

// File: rtl/evt_timer_count.sv
// Module: the 16-bit counter, the high-byte buffer and the sticky overflow
// flag. In 8-bit mode only the low byte counts and the high byte is kept.
// Assumes: at most one of load_lo, wr_buf, rd_lo, flag_wr per cycle.
module evt_timer_count #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wide,
    input  logic              run,
    input  logic              step,
    input  logic              hold_busy,
    input  logic              load_lo,
    input  logic              wr_buf,
    input  logic              rd_lo,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              flag_wr,
    input  logic              flag_wdata,
    output logic [2*BYTE_W-1:0] cnt,
    output logic [BYTE_W-1:0] buf_out,
    output logic              ovf
);

    localparam int CNT_W = 2 * BYTE_W;

    logic [CNT_W-1:0]  cnt_q;
    logic [BYTE_W-1:0] buf_q;
    logic              ovf_q;
    logic              wrap;

    // a wrap happens when all bits of the active width are ones
    assign wrap = wide ? (&cnt_q) : (&cnt_q[BYTE_W-1:0]);

    // counter: bus load has priority over a step
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_lo) begin
            if (wide) cnt_q <= {buf_q, wdata};
            else      cnt_q[BYTE_W-1:0] <= wdata;
        end else if (step) begin
            if (wide) cnt_q <= cnt_q + CNT_W'(1);
            else      cnt_q[BYTE_W-1:0] <= cnt_q[BYTE_W-1:0] + BYTE_W'(1);
        end
    end

    // high-byte buffer: written by the bus, refreshed by a low-byte read in 16-bit mode
    always_ff @(posedge clk) begin
        if (!rst_n)             buf_q <= '0;
        else if (wr_buf)        buf_q <= wdata;
        else if (rd_lo && wide) buf_q <= cnt_q[CNT_W-1:BYTE_W];
    end

    // sticky overflow flag: a wrap wins over a software write
    always_ff @(posedge clk) begin
        if (!rst_n)                        ovf_q <= 1'b0;
        else if (step && wrap && !load_lo) ovf_q <= 1'b1;
        else if (flag_wr)                  ovf_q <= flag_wdata;
    end

    assign cnt     = cnt_q;
    assign buf_out = buf_q;
    assign ovf     = ovf_q;

    // R9: a counted wrap always raises the flag
    assert_wrap_sets_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (step && wrap && !load_lo) |=> ovf_q);

    // R9: in 8-bit mode the true high byte never moves
    assert_narrow_high_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !wide |=> $stable(cnt_q[CNT_W-1:BYTE_W]));

    // R10: the flag only drops through a software write
    assert_flag_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_q && !flag_wr) |=> ovf_q);

    // R3: the counter is frozen during the hold-off window
    assert_hold_freezes_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_busy && !load_lo) |=> $stable(cnt_q));

    // R11: a cleared run bit freezes the counter
    assert_run_halts_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !load_lo) |=> $stable(cnt_q));

    // R8: a buffer write alone leaves the counter untouched
    assert_buffer_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_buf && !step) |=> $stable(cnt_q));

endmodule

// File: rtl/evt_timer.sv
// Module: top of the timer/counter. Decodes the register bus, holds the
// control byte and ties the edge detector, pacing logic and counter together.
// Assumes: bus strobes are one access per cycle; bus_rdata is combinational.
module evt_timer
    import evt_timer_pkg::*;
#(
    parameter int TICK_DIV    = 4,
    parameter int HOLD_TICKS  = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    input  logic              ext_in,
    output logic              ovf_flag
);

    ctrl_t               ctrl_q;
    reg_addr_e           addr;
    logic                wr_ctrl;
    logic                wr_lo;
    logic                wr_hi;
    logic                wr_flag;
    logic                rd_lo;
    logic                ext_pulse;
    logic                step;
    logic                hold_busy;
    logic [2*BYTE_W-1:0] cnt;
    logic [BYTE_W-1:0]   buf_val;
    logic                ovf;

    assign addr    = reg_addr_e'(bus_addr);
    assign wr_ctrl = bus_wr && (addr == A_CTRL);
    assign wr_lo   = bus_wr && (addr == A_CNT_LO);
    assign wr_hi   = bus_wr && (addr == A_CNT_HI);
    assign wr_flag = bus_wr && (addr == A_FLAG);
    assign rd_lo   = bus_rd && (addr == A_CNT_LO);

    // control byte register
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl_q <= CTRL_RST;
        else if (wr_ctrl) ctrl_q <= ctrl_t'(bus_wdata);
    end

    evt_timer_edge #(
        .STAGES   (SYNC_STAGES)
    ) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin      (ext_in),
        .fall_sel (ctrl_q.fall),
        .pulse    (ext_pulse)
    );

    evt_timer_pace #(
        .TICK_DIV   (TICK_DIV),
        .HOLD_TICKS (HOLD_TICKS),
        .PS_W       (PS_W)
    ) u_pace (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (ctrl_q.run),
        .ext_sel    (ctrl_q.ext),
        .bypass     (ctrl_q.bypass),
        .sel        (ctrl_q.sel),
        .ext_pulse  (ext_pulse),
        .load       (wr_lo),
        .step       (step),
        .hold_busy  (hold_busy)
    );

    evt_timer_count #(
        .BYTE_W     (BYTE_W)
    ) u_count (
        .clk        (clk),
        .rst_n      (rst_n),
        .wide       (ctrl_q.wide),
        .run        (ctrl_q.run),
        .step       (step),
        .hold_busy  (hold_busy),
        .load_lo    (wr_lo),
        .wr_buf     (wr_hi),
        .rd_lo      (rd_lo),
        .wdata      (bus_wdata),
        .flag_wr    (wr_flag),
        .flag_wdata (bus_wdata[0]),
        .cnt        (cnt),
        .buf_out    (buf_val),
        .ovf        (ovf)
    );

    // read-data multiplexer
    always_comb begin
        case (addr)
            A_CTRL:   bus_rdata = ctrl_q;
            A_CNT_LO: bus_rdata = cnt[BYTE_W-1:0];
            A_CNT_HI: bus_rdata = buf_val;
            default:  bus_rdata = {{(BYTE_W-1){1'b0}}, ovf};
        endcase
    end

    assign ovf_flag = ovf;

    // R10: the output pin follows the flag read back on the bus
    assert_flag_pin_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == A_FLAG) |-> (bus_rdata[0] == ovf_flag));

endmodule

// File: tb/test_evt_timer.sv
module test_evt_timer;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       ext_in = 1'b0;
    logic       ovf_flag;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    evt_timer i_evt_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .ext_in    (ext_in),
        .ovf_flag  (ovf_flag)
    );

    task automatic check(input string req, input int got, input int exp);
        n_checks++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    // each bus task is entered at a falling edge and consumes exactly one rising edge
    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        wait_clk(3);
        rst_n = 1'b1;
        wait_clk(1);

        // R1 reset state
        rd(2'd0, v); check("R1 ctrl", v, 8'h9F);
        rd(2'd1, v); check("R1 low", v, 0);
        rd(2'd2, v); check("R1 buffer", v, 0);
        rd(2'd3, v); check("R1 flag", v, 0);
        check("R1 pin", ovf_flag, 0);

        // R2/R3 internal tick, bypass, 8-bit: value + max(N-2,0) after 4N clocks
        wr(2'd0, 8'h88);
        for (int n = 0; n < 10; n++) begin
            wr(2'd1, 8'h10);
            wait_clk(4 * n);
            rd(2'd1, v);
            check((n <= 2) ? "R3 hold-off" : "R2 tick rate", v, 8'h10 + ((n > 2) ? n - 2 : 0));
        end

        // R4 prescaler sweep over every ratio
        for (int s = 0; s < 8; s++) begin
            int r;
            r = 2 << s;
            wr(2'd0, 8'h80 | s[7:0]);
            wr(2'd1, 8'h00);
            wait_clk(4 * (2 + 4 * r - 1));
            rd(2'd1, v); check("R4 prescale full", v, 3);
            wr(2'd1, 8'h00);
            wait_clk(4 * (2 + 3 * r - 1));
            rd(2'd1, v); check("R4 prescale short", v, 2);
        end

        // R11 run bit cleared halts counting
        wr(2'd0, 8'h08);
        wr(2'd1, 8'h40);
        wait_clk(40);
        rd(2'd1, v); check("R11 halted", v, 8'h40);

        // R9 8-bit wrap: set true high 0x5A first, then wrap low byte
        wr(2'd0, 8'h48);
        wr(2'd2, 8'h5A);
        wr(2'd1, 8'hFD);
        wr(2'd0, 8'h88);
        wr(2'd1, 8'hFD);
        wait_clk(20);
        rd(2'd1, v); check("R9 8-bit wrap low", v, 8'h00);
        rd(2'd3, v); check("R9 8-bit flag", v, 1);
        check("R9 pin", ovf_flag, 1);
        wr(2'd0, 8'h48);
        wr(2'd2, 8'h12);
        rd(2'd1, v);
        rd(2'd2, v); check("R9 8-bit high kept / R7 copy / R8 buffer only", v, 8'h5A);
        wait_clk(30);
        rd(2'd3, v); check("R10 sticky", v, 1);
        wr(2'd3, 8'h00);
        rd(2'd3, v); check("R10 cleared", v, 0);
        check("R10 pin cleared", ovf_flag, 0);

        // R8 atomic 16-bit load while stopped
        wr(2'd2, 8'h12);
        wr(2'd1, 8'hFE);
        rd(2'd1, v); check("R8 low", v, 8'hFE);
        rd(2'd2, v); check("R8 high", v, 8'h12);

        // R7 matched pair while running across a byte boundary
        wr(2'd0, 8'hC8);
        wr(2'd2, 8'h12);
        wr(2'd1, 8'hFE);
        wait_clk(12);
        rd(2'd1, v); check("R7 low", v, 8'hFF);
        wait_clk(16);
        rd(2'd2, v); check("R7 buffered high", v, 8'h12);
        rd(2'd1, v);
        rd(2'd2, v); check("R7 refreshed high", v, 8'h13);

        // R9 16-bit wrap
        wr(2'd3, 8'h00);
        wr(2'd2, 8'hFF);
        wr(2'd1, 8'hFE);
        wait_clk(16);
        rd(2'd1, v); check("R9 16-bit low", v, 8'h00);
        rd(2'd2, v); check("R9 16-bit high", v, 8'h00);
        rd(2'd3, v); check("R9 16-bit flag", v, 1);

        // R5 external rising edges, 8-bit, bypass
        wr(2'd0, 8'h98);
        ext_in = 1'b0;
        wait_clk(8);
        wr(2'd1, 8'h00);
        wait_clk(12);
        for (int k = 0; k < 5; k++) begin
            ext_in = 1'b1; wait_clk(6);
            ext_in = 1'b0; wait_clk(6);
        end
        ext_in = 1'b1; wait_clk(10);
        rd(2'd1, v); check("R5 rising count", v, 6);

        // R6 falling edges only
        wr(2'd0, 8'hB8);
        wr(2'd1, 8'h00);
        wait_clk(12);
        for (int k = 0; k < 5; k++) begin
            ext_in = 1'b0; wait_clk(6);
            ext_in = 1'b1; wait_clk(6);
        end
        wait_clk(4);
        rd(2'd1, v); check("R6 falling count", v, 5);
        ext_in = 1'b0; wait_clk(8);
        rd(2'd1, v); check("R6 single fall", v, 6);

        // R3 external edge inside hold-off is dropped
        wr(2'd0, 8'h98);
        wait_clk(10);
        wr(2'd1, 8'h20);
        ext_in = 1'b1;
        wait_clk(10);
        rd(2'd1, v); check("R3 edge blocked", v, 8'h20);
        ext_in = 1'b0; wait_clk(6);
        ext_in = 1'b1; wait_clk(8);
        rd(2'd1, v); check("R5 edge after hold", v, 8'h21);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule